// File: doc/BRIEF.md
# USB Bus Turnaround Timeout Timer

This block watches the quiet interval on a USB link between two phases of one transaction and reports when the far end takes too long to answer. Each time the packet engine sees the end-of-packet marker, it passes along the kind of transaction in progress and the phase of the packet that just ended. If a reply is owed, the timer starts. A reply is owed after the token of a SETUP or OUT transaction, because the data packet comes next. It is also owed after the data packet of an IN transaction, because the handshake comes next. After that point the timer counts bit-time ticks.

If the line leaves IDLE soon enough, the timer stops quietly. If more than the allowed number of bit times go by first, the block raises a single-cycle timeout pulse and returns to its disarmed state. A second status output shows whether a reply is currently awaited. Packet decoding, error logging and retries belong to the surrounding engine.

Top module: `usb_ta_timer`

## Requirements
- R1: An EOP pulse with `xfer_kind` 2'b00 (SETUP) or 2'b01 (OUT) and `pkt_phase` 2'b00 (token) arms the timer. `await_resp` is high from the cycle after that EOP.
- R2: An EOP pulse with `xfer_kind` 2'b10 (IN) and `pkt_phase` 2'b01 (data) arms the timer in the same way.
- R3: An EOP pulse with any other pair disarms the timer and leaves it disarmed. This includes handshake phase 2'b10, the IN token, SETUP/OUT data, and the unused kind 2'b11.
- R4: Counting starts from the arming EOP, and a tick in that same cycle is not counted. If the 17th counted `bit_tick` arrives while the timer is armed, with no `idle_exit` in that cycle, `ta_timeout` is high in the next cycle.
- R5: An `idle_exit` pulse while the timer is armed disarms it with no timeout. This holds even when the pulse shares a cycle with the 17th tick.
- R6: `ta_timeout` lasts exactly one cycle, and `await_resp` is low while it is high.
- R7: The count saturates. A long idle stretch after a timeout gives no further timeout pulses.
- R8: An EOP pulse takes priority over `bit_tick` and `idle_exit` in the same cycle. It restarts the count from zero under the R1 to R3 rules.
- R9: `bit_tick` and `idle_exit` have no effect while the timer is disarmed.
- R10: While `rst_n` is low, and in the first cycle after it rises, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One pulse per USB bit time |
| eop_seen | input | 1 | Pulse at the end of an EOP |
| idle_exit | input | 1 | Pulse when the line leaves IDLE |
| xfer_kind | input | 2 | Transaction kind: 00 SETUP, 01 OUT, 10 IN, 11 unused |
| pkt_phase | input | 2 | Phase of the packet that just ended: 00 token, 01 data, 10 handshake |
| ta_timeout | output | 1 | One-cycle turnaround timeout pulse |
| await_resp | output | 1 | High while a reply is awaited |

## Verification
Both outputs are registered. Each result is therefore due exactly one clock after the edge that captures its stimulus. An arming EOP shows up on `await_resp` one cycle later. The 17th tick shows up on `ta_timeout` one cycle later. An `idle_exit` clears `await_resp` one cycle later.

The bench drives its inputs on the falling edge. At each rising edge it advances an integer-based reference model. One time unit after that edge it compares both outputs, so the model and the design are always compared for the same edge. Scenarios probe the timeout boundary on both sides, EOP collisions, and long idle stretches after a timeout.

// File: rtl/usb_ta_pkg.sv
package usb_ta_pkg;

  typedef enum logic [1:0] {
    KIND_SETUP = 2'b00,
    KIND_OUT   = 2'b01,
    KIND_IN    = 2'b10,
    KIND_RSVD  = 2'b11
  } xfer_kind_e;

  typedef enum logic [1:0] {
    PH_TOKEN = 2'b00,
    PH_DATA  = 2'b01,
    PH_HSHK  = 2'b10,
    PH_RSVD  = 2'b11
  } pkt_phase_e;

  // A reply is owed only after these packet phases.
  function automatic logic reply_owed(xfer_kind_e kind, pkt_phase_e ph);
    logic owed;
    unique case (kind)
      KIND_SETUP, KIND_OUT: owed = (ph == PH_TOKEN);
      KIND_IN:              owed = (ph == PH_DATA);
      default:              owed = 1'b0;
    endcase
    return owed;
  endfunction

  // Saturating increment toward a ceiling.
  function automatic int unsigned sat_step(int unsigned cur, int unsigned ceil);
    return (cur >= ceil) ? ceil : cur + 1;
  endfunction

endpackage

// File: rtl/usb_ta_arm_decode.sv
module usb_ta_arm_decode
  import usb_ta_pkg::*;
(
  input  logic       eop_seen,
  input  logic [1:0] xfer_kind,
  input  logic [1:0] pkt_phase,
  output logic       arm_evt,
  output logic       drop_evt
);
  logic owed;

  always_comb begin
    owed     = reply_owed(xfer_kind_e'(xfer_kind), pkt_phase_e'(pkt_phase));
    arm_evt  = eop_seen & owed;
    drop_evt = eop_seen & ~owed;
  end
endmodule

// File: rtl/usb_ta_bit_counter.sv
module usb_ta_bit_counter
  import usb_ta_pkg::*;
#(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          advance,
  output logic [CW-1:0] count,
  output logic          at_limit
);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (clear)   count <= '0;
    else if (advance) count <= CW'(sat_step(int'(count), LIMIT));
  end

  assign at_limit = (count == LIM_V);

  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIM_V);

  assert_cnt_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !clear && !at_limit) |=> (count == $past(count) + 1'b1));

  assert_cnt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));
endmodule

// File: rtl/usb_ta_timer.sv
module usb_ta_timer
  import usb_ta_pkg::*;
#(
  parameter int unsigned LIMIT = 16,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       eop_seen,
  input  logic       idle_exit,
  input  logic [1:0] xfer_kind,
  input  logic [1:0] pkt_phase,
  output logic       ta_timeout,
  output logic       await_resp
);
  logic          arm_evt, drop_evt;
  logic          armed;
  logic          idle_evt, tick_evt, expire_evt;
  logic [CW-1:0] count;
  logic          at_limit;

  usb_ta_arm_decode u_decode (
    .eop_seen (eop_seen),
    .xfer_kind(xfer_kind),
    .pkt_phase(pkt_phase),
    .arm_evt  (arm_evt),
    .drop_evt (drop_evt)
  );

  // Named internal events, EOP always wins.
  assign idle_evt   = armed & idle_exit & ~eop_seen;
  assign tick_evt   = armed & bit_tick & ~idle_exit & ~eop_seen;
  assign expire_evt = tick_evt & at_limit;

  usb_ta_bit_counter #(.LIMIT(LIMIT)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (eop_seen),
    .advance (tick_evt),
    .count   (count),
    .at_limit(at_limit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      ta_timeout <= 1'b0;
    end else begin
      ta_timeout <= expire_evt;
      if (arm_evt)                    armed <= 1'b1;
      else if (drop_evt)              armed <= 1'b0;
      else if (idle_evt | expire_evt) armed <= 1'b0;
    end
  end

  assign await_resp = armed;

  assert_arm_from_eop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(eop_seen));

  assert_no_arm_hshk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (eop_seen && pkt_phase == 2'b10) |=> !await_resp);

  assert_idle_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |=> (!await_resp && !ta_timeout));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ta_timeout |=> !ta_timeout);

  assert_timeout_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ta_timeout |-> !await_resp);

  assert_eop_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eop_seen |=> !ta_timeout);

  assert_disarmed_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !eop_seen) |=> (!await_resp && !ta_timeout));
endmodule

// File: tb/usb_ta_timer_bench.sv
module usb_ta_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_tick = 1'b0, eop_seen = 1'b0, idle_exit = 1'b0;
  logic [1:0] xfer_kind = 2'b00, pkt_phase = 2'b00;
  logic ta_timeout, await_resp;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 1'b0;

  // reference model state
  bit m_armed = 1'b0, m_err = 1'b0;
  int m_bits  = 0;

  usb_ta_timer #(.LIMIT(LIMIT)) u_usb_ta_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .eop_seen(eop_seen),
    .idle_exit(idle_exit), .xfer_kind(xfer_kind), .pkt_phase(pkt_phase),
    .ta_timeout(ta_timeout), .await_resp(await_resp)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit owes(logic [1:0] k, logic [1:0] p);
    if (k == 2'b10) return p == 2'b01;
    if (k == 2'b11) return 1'b0;
    return p == 2'b00;
  endfunction

  task automatic step(input bit t, input bit e, input bit i,
                      input logic [1:0] k, input logic [1:0] p, input string tag);
    @(negedge clk);
    bit_tick = t; eop_seen = e; idle_exit = i; xfer_kind = k; pkt_phase = p;
    @(posedge clk);
    m_err = 1'b0;
    if (e) begin
      m_armed = owes(k, p);
      m_bits  = 0;
    end else if (m_armed && i) begin
      m_armed = 1'b0;
    end else if (m_armed && t) begin
      m_bits++;
      if (m_bits > LIMIT) begin
        m_err   = 1'b1;
        m_armed = 1'b0;
      end
    end
    #1;
    if (ta_timeout === 1'b1) pulses++;
    check(tag, ta_timeout, m_err, "ta_timeout");
    check(tag, await_resp, m_armed, "await_resp");
  endtask

  task automatic ticks(input int n, input string tag);
    for (int j = 0; j < n; j++) begin
      step(1, 0, 0, 2'b00, 2'b00, tag);
      step(0, 0, 0, 2'b00, 2'b00, tag);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", ta_timeout, 1'b0, "ta_timeout in reset");
    check("R10", await_resp, 1'b0, "await_resp in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R10", ta_timeout, 1'b0, "ta_timeout after reset");
    check("R10", await_resp, 1'b0, "await_resp after reset");

    // R9: stimulus while disarmed
    ticks(20, "R9");
    step(0, 0, 1, 2'b00, 2'b00, "R9");

    // R1 R4 R6: SETUP token, full timeout
    step(0, 1, 0, 2'b00, 2'b00, "R1");
    pulses = 0;
    ticks(17, "R4");
    check("R4", pulses == 1, 1'b1, "one timeout after 17 ticks");
    // R7: long idle after timeout
    pulses = 0;
    ticks(40, "R7");
    check("R7", pulses == 0, 1'b1, "no repeat timeout");

    // R1 R5: OUT token, reply after 10 ticks
    step(1, 1, 0, 2'b01, 2'b00, "R1");
    ticks(10, "R5");
    step(0, 0, 1, 2'b00, 2'b00, "R5");
    pulses = 0;
    ticks(20, "R5");
    check("R5", pulses == 0, 1'b1, "no timeout after idle exit");

    // R2 R5: IN data, idle exit together with the 17th tick
    step(0, 1, 0, 2'b10, 2'b01, "R2");
    ticks(16, "R2");
    pulses = 0;
    step(1, 0, 1, 2'b00, 2'b00, "R5");
    ticks(5, "R5");
    check("R5", pulses == 0, 1'b1, "idle exit wins over 17th tick");

    // R3: non-arming pairs
    step(0, 1, 0, 2'b10, 2'b00, "R3");
    step(0, 1, 0, 2'b01, 2'b01, "R3");
    step(0, 1, 0, 2'b00, 2'b01, "R3");
    step(0, 1, 0, 2'b11, 2'b00, "R3");
    step(0, 1, 0, 2'b10, 2'b10, "R3");
    step(0, 1, 0, 2'b10, 2'b01, "R3");
    step(0, 1, 0, 2'b10, 2'b10, "R3");
    ticks(20, "R3");

    // R8: EOP restarts count mid-window, same cycle as a tick
    step(0, 1, 0, 2'b00, 2'b00, "R8");
    ticks(12, "R8");
    step(1, 1, 0, 2'b01, 2'b00, "R8");
    pulses = 0;
    ticks(16, "R8");
    check("R8", pulses == 0, 1'b1, "restart delays timeout");
    ticks(1, "R6");
    check("R6", pulses == 1, 1'b1, "timeout after restarted window");
    // R8: EOP with idle exit while armed, disarming pair
    step(0, 1, 0, 2'b10, 2'b01, "R8");
    step(1, 1, 1, 2'b10, 2'b10, "R8");
    ticks(20, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule